// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block is a write-only serial slave that lets a host controller load a small bank of 10-bit configuration words. The host pulls the active-low select line down, clocks in one 16-bit frame on the serial data line, and releases select. The frame holds a 2-bit operation code, a 4-bit register address and a 10-bit data word. The operation code goes out first and the data word last. Within each field the least significant bit goes first.

The select, serial clock and serial data pins are brought into the system clock domain through synchroniser flops. Serial clock rising edges are then detected there, so the system clock must run several times faster than the serial clock. When select rises, the frame is checked. It must be complete, carry the write code and address one of the five registers. Only then are the addressed register, a one-cycle done strobe and the written address updated together. Downstream logic also uses the strobe to restart its loop-boost window counter.

Top module: `scri_ctrl_regs`

## Requirements
- R1: After reset, register 0 (`cfg_ctl_a`) holds 0x040 and register 4 (`cfg_black`) holds 0x040 (decimal 64). Registers 1, 2 and 3 hold 0. `wr_done` is low.
- R2: The first serial bit is operation code bit 0, then operation code bit 1, then address bits 0 to 3, then data bits 0 to 9. A committed frame loads its data word into the register at its address: 0 `cfg_ctl_a`, 1 `cfg_ctl_b`, 2 `cfg_ctl_c`, 3 `cfg_gain`, 4 `cfg_black`.
- R3: Only operation code 2'b00 is a write. A frame carrying 2'b01, 2'b10 or 2'b11 changes no register and gives no strobe.
- R4: A frame addressing any location from 5 to 15 changes no register and gives no strobe.
- R5: If select rises after fewer than 16 serial clock rising edges, the frame is dropped. No register changes and no strobe is given.
- R6: Serial clock edges after the sixteenth are ignored. The frame commits with its first 16 bits.
- R7: A frame takes effect only when select rises. While select stays low, even after 16 bits, no register changes.
- R8: Each committed frame raises `wr_done` for exactly one system clock. `wr_addr` shows the written address while `wr_done` is high.
- R9: Serial clock and data activity while select is high shifts nothing and commits nothing.
- R10: A committed write changes only the addressed register. The other four keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low, high when idle |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data in |
| cfg_ctl_a | output | 10 | Register 0, control word A |
| cfg_ctl_b | output | 10 | Register 1, control word B |
| cfg_ctl_c | output | 10 | Register 2, control word C (gain step and boost settings) |
| cfg_gain | output | 10 | Register 3, amplifier gain code |
| cfg_black | output | 10 | Register 4, black level target code |
| wr_done | output | 1 | One-cycle pulse per committed write |
| wr_addr | output | 4 | Address of the last committed write |

## Verification
A bit counter that is off by one, or a shift in the wrong direction, shows on the very next frame. The wrong register takes the word, or its bits come out rotated or reversed, three system clocks after select rises. A completeness or decode check that lets a bad frame through shows at that same point as a strobe that should not occur, or as a changed register. A counter that fails to clear while select is high spoils the frame that follows, so every rejected-frame case is followed by a normal write. Early commits, made before select rises, show as a register change while select is still low.

// File: rtl/scri_pkg.sv
package scri_pkg;

    localparam int OP_W       = 2;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 10;
    localparam int FRAME_BITS = OP_W + ADDR_W + DATA_W;
    localparam int NUM_REGS   = 5;

    localparam logic [OP_W-1:0] OPC_WRITE = 2'b00;

    typedef logic [DATA_W-1:0] word_t;

    // Reset contents: control word A has bit 6 set, black target is 64.
    function automatic word_t reset_value(input int idx);
        word_t v;
        v = '0;
        if (idx == 0) v[6] = 1'b1;
        if (idx == 4) v = word_t'(64);
        return v;
    endfunction

endpackage

// File: rtl/scri_sync.sv
module scri_sync #(
    parameter int           WIDTH   = 3,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/scri_deframer.sv
module scri_deframer
    import scri_pkg::*;
#(
    parameter int FB  = FRAME_BITS,
    parameter int OPW = OP_W,
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_s,
    input  logic          sclk_s,
    input  logic          sdi_s,
    output logic          commit_vld,
    output logic [OPW-1:0] commit_op,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data
);

    localparam int CNT_W = $clog2(FB + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FB);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [FB-1:0]    sr;
        logic             cs_prev;
        logic             sclk_prev;
    } dfr_state_t;

    dfr_state_t st_d, st_q;
    logic       sclk_rise;
    logic       cs_rise;

    always_comb begin
        st_d           = st_q;
        st_d.cs_prev   = cs_n_s;
        st_d.sclk_prev = sclk_s;
        sclk_rise      = sclk_s & ~st_q.sclk_prev;
        cs_rise        = cs_n_s & ~st_q.cs_prev;

        if (cs_n_s) begin
            st_d.cnt = '0;
        end else if (sclk_rise && (st_q.cnt != CNT_FULL)) begin
            // new bit enters at the top, so the first bit ends at index 0
            st_d.sr  = {sdi_s, st_q.sr[FB-1:1]};
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt       <= '0;
            st_q.sr        <= '0;
            st_q.cs_prev   <= 1'b1;
            st_q.sclk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_vld  = cs_rise && (st_q.cnt == CNT_FULL);
    assign commit_op   = st_q.sr[OPW-1:0];
    assign commit_addr = st_q.sr[OPW +: AW];
    assign commit_data = st_q.sr[OPW+AW +: DW];

endmodule

// File: rtl/scri_regbank.sv
module scri_regbank
    import scri_pkg::*;
#(
    parameter int NR  = NUM_REGS,
    parameter int OPW = OP_W,
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_vld,
    input  logic [OPW-1:0]        commit_op,
    input  logic [AW-1:0]         commit_addr,
    input  logic [DW-1:0]         commit_data,
    output logic [NR-1:0][DW-1:0] regs_o,
    output logic                  wr_done_o,
    output logic [AW-1:0]         wr_addr_o
);

    typedef struct packed {
        logic [NR-1:0][DW-1:0] regs;
        logic                  done;
        logic [AW-1:0]         addr;
    } bank_state_t;

    bank_state_t bk_d, bk_q;
    logic        accept;

    always_comb begin
        bk_d      = bk_q;
        bk_d.done = 1'b0;
        accept    = commit_vld
                 && (commit_op == OPC_WRITE)
                 && (commit_addr < AW'(NR));
        if (accept) begin
            bk_d.done = 1'b1;
            bk_d.addr = commit_addr;
            for (int i = 0; i < NR; i++) begin
                if (commit_addr == AW'(i)) bk_d.regs[i] = commit_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) bk_q.regs[i] <= DW'(reset_value(i));
            bk_q.done <= 1'b0;
            bk_q.addr <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign regs_o    = bk_q.regs;
    assign wr_done_o = bk_q.done;
    assign wr_addr_o = bk_q.addr;

endmodule

// File: rtl/scri_ctrl_regs.sv
module scri_ctrl_regs
    import scri_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic [DATA_W-1:0] cfg_ctl_a,
    output logic [DATA_W-1:0] cfg_ctl_b,
    output logic [DATA_W-1:0] cfg_ctl_c,
    output logic [DATA_W-1:0] cfg_gain,
    output logic [DATA_W-1:0] cfg_black,
    output logic              wr_done,
    output logic [ADDR_W-1:0] wr_addr
);

    logic [2:0]                      pins_s;
    logic                            commit_vld;
    logic [OP_W-1:0]                 commit_op;
    logic [ADDR_W-1:0]               commit_addr;
    logic [DATA_W-1:0]               commit_data;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    scri_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b110)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({cs_n, sclk, sdi}),
        .sync_o (pins_s)
    );

    scri_deframer u_dfr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s     (pins_s[2]),
        .sclk_s     (pins_s[1]),
        .sdi_s      (pins_s[0]),
        .commit_vld (commit_vld),
        .commit_op  (commit_op),
        .commit_addr(commit_addr),
        .commit_data(commit_data)
    );

    scri_regbank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_vld (commit_vld),
        .commit_op  (commit_op),
        .commit_addr(commit_addr),
        .commit_data(commit_data),
        .regs_o     (regs),
        .wr_done_o  (wr_done),
        .wr_addr_o  (wr_addr)
    );

    assign cfg_ctl_a = regs[0];
    assign cfg_ctl_b = regs[1];
    assign cfg_ctl_c = regs[2];
    assign cfg_gain  = regs[3];
    assign cfg_black = regs[4];

endmodule

// File: rtl/scri_checker.sv
module scri_checker
    import scri_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic [DATA_W-1:0] cfg_ctl_a,
    input logic [DATA_W-1:0] cfg_ctl_b,
    input logic [DATA_W-1:0] cfg_ctl_c,
    input logic [DATA_W-1:0] cfg_gain,
    input logic [DATA_W-1:0] cfg_black,
    input logic              wr_done,
    input logic [ADDR_W-1:0] wr_addr
);

    logic [DATA_W-1:0] r [NUM_REGS];
    assign r[0] = cfg_ctl_a;
    assign r[1] = cfg_ctl_b;
    assign r[2] = cfg_ctl_c;
    assign r[3] = cfg_gain;
    assign r[4] = cfg_black;

    logic [NUM_REGS*DATA_W-1:0] flat;
    assign flat = {cfg_ctl_a, cfg_ctl_b, cfg_ctl_c, cfg_gain, cfg_black};

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done); // R8

    AST_DONE_ADDR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> (wr_addr < ADDR_W'(NUM_REGS))); // R4

    AST_NO_CHANGE_WITHOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_done |-> $stable(flat)); // R7

    AST_DONE_SELECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> cs_n); // R7

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_other
        AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_done && (wr_addr != ADDR_W'(i))) |-> $stable(r[i])); // R10
    end

endmodule

bind scri_ctrl_regs scri_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .cfg_ctl_a(cfg_ctl_a),
    .cfg_ctl_b(cfg_ctl_b),
    .cfg_ctl_c(cfg_ctl_c),
    .cfg_gain (cfg_gain),
    .cfg_black(cfg_black),
    .wr_done  (wr_done),
    .wr_addr  (wr_addr)
);

// File: tb/scri_ctrl_regs_tb.sv
`timescale 1ns/1ps
module scri_ctrl_regs_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [9:0] cfg_ctl_a, cfg_ctl_b, cfg_ctl_c, cfg_gain, cfg_black;
    logic       wr_done;
    logic [3:0] wr_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int pulse_cycles = 0;
    int pulse_starts = 0;
    logic [3:0] seen_addr = '0;
    logic prev_done = 1'b0;
    bit   finished = 0;

    always #10 clk = ~clk;

    scri_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .cfg_ctl_a(cfg_ctl_a), .cfg_ctl_b(cfg_ctl_b), .cfg_ctl_c(cfg_ctl_c),
        .cfg_gain(cfg_gain), .cfg_black(cfg_black),
        .wr_done(wr_done), .wr_addr(wr_addr)
    );

    always @(negedge clk) begin
        if (wr_done) begin
            pulse_cycles++;
            seen_addr = wr_addr;
            if (!prev_done) pulse_starts++;
        end
        prev_done = wr_done;
    end

    function automatic logic [9:0] get_reg(input int i);
        case (i)
            0: return cfg_ctl_a;
            1: return cfg_ctl_b;
            2: return cfg_ctl_c;
            3: return cfg_gain;
            default: return cfg_black;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clr_mon();
        pulse_cycles = 0;
        pulse_starts = 0;
    endtask

    // frame bit k is sent k-th; bits past 16 are sent as ones
    task automatic shift_frame(input logic [1:0] op, input logic [3:0] addr,
                               input logic [9:0] data, input int nbits,
                               input bit keep_low);
        logic [15:0] fr;
        fr = {data, addr, op};
        @(negedge clk) cs_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            sdi = (k < 16) ? fr[k] : 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (3) @(negedge clk);
        sdi = 1'b0;
        if (!keep_low) cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic expect_bank(input string req, input logic [9:0] e [5]);
        for (int i = 0; i < 5; i++) chk(req, $sformatf("reg%0d", i), 32'(get_reg(i)), 32'(e[i]));
    endtask

    logic [9:0] model [5];

    task automatic good_write(input string req, input logic [3:0] addr, input logic [9:0] data);
        clr_mon();
        shift_frame(2'b00, addr, data, 16, 0);
        model[addr] = data;
        expect_bank(req, model);
        chk("R8", "pulse cycles", 32'(pulse_cycles), 32'd1);
        chk("R8", "wr_addr", 32'(seen_addr), 32'(addr));
    endtask

    task automatic t_reset();
        model[0] = 10'h040; model[1] = '0; model[2] = '0; model[3] = '0; model[4] = 10'd64;
        expect_bank("R1", model);
        chk("R1", "wr_done", 32'(wr_done), 32'd0);
    endtask

    task automatic t_each_address();
        good_write("R2", 4'd3, 10'h2A5);
        good_write("R2", 4'd0, 10'h155);
        good_write("R2", 4'd1, 10'h3C1);
        good_write("R2", 4'd2, 10'h007);
        good_write("R10", 4'd4, 10'h201);
        good_write("R10", 4'd3, 10'h0F0);
    endtask

    task automatic t_bad_opcode();
        for (int o = 1; o < 4; o++) begin
            clr_mon();
            shift_frame(2'(o), 4'd1, 10'h0AA, 16, 0);
            expect_bank("R3", model);
            chk("R3", "pulse cycles", 32'(pulse_cycles), 32'd0);
        end
    endtask

    task automatic t_bad_address();
        logic [3:0] bad [3] = '{4'd5, 4'd9, 4'd15};
        for (int i = 0; i < 3; i++) begin
            clr_mon();
            shift_frame(2'b00, bad[i], 10'h3FF, 16, 0);
            expect_bank("R4", model);
            chk("R4", "pulse cycles", 32'(pulse_cycles), 32'd0);
        end
    endtask

    task automatic t_short_frame();
        clr_mon();
        shift_frame(2'b00, 4'd2, 10'h111, 15, 0);
        expect_bank("R5", model);
        chk("R5", "pulse after 15 bits", 32'(pulse_cycles), 32'd0);
        clr_mon();
        shift_frame(2'b00, 4'd2, 10'h111, 0, 0);
        chk("R5", "pulse after 0 bits", 32'(pulse_cycles), 32'd0);
        good_write("R5", 4'd2, 10'h2D2);
    endtask

    task automatic t_long_frame();
        clr_mon();
        shift_frame(2'b00, 4'd4, 10'h04C, 20, 0);
        model[4] = 10'h04C;
        expect_bank("R6", model);
        chk("R6", "pulse cycles", 32'(pulse_cycles), 32'd1);
    endtask

    task automatic t_hold_until_release();
        clr_mon();
        shift_frame(2'b00, 4'd0, 10'h3A3, 16, 1);
        repeat (20) @(negedge clk);
        expect_bank("R7", model);
        chk("R7", "pulse while low", 32'(pulse_cycles), 32'd0);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        model[0] = 10'h3A3;
        expect_bank("R7", model);
        chk("R7", "pulse after release", 32'(pulse_starts), 32'd1);
    endtask

    task automatic t_idle_clocking();
        clr_mon();
        for (int k = 0; k < 20; k++) begin
            sdi = k[0];
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (10) @(negedge clk);
        expect_bank("R9", model);
        chk("R9", "pulse while idle", 32'(pulse_cycles), 32'd0);
        good_write("R9", 4'd1, 10'h099);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_each_address();
        t_bad_opcode();
        t_bad_address();
        t_short_frame();
        t_long_frame();
        t_hold_until_release();
        t_idle_clocking();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule